// File: doc/BRIEF.md
# ECC Status Byte Accumulator

After an ECC-protected page has been decoded, the decoder leaves one status byte per chunk in an auxiliary buffer, just past the metadata area. This block walks those bytes through a synchronous byte-read port and sorts each one into a class. A chunk can be clean, erased, uncorrectable, or corrected by some number of bits. The block reports two results: the total number of corrected bits and the number of chunks that could not be recovered.

A single `start` pulse carries the chunk count, which is the page data size divided by the chunk data size. The block clears its totals and reads the status bytes at consecutive addresses. It then raises `done` for one cycle, and at that point both totals are final. The totals hold until the next accepted start. The first status byte sits at the metadata size rounded up to a multiple of four.

Top module: `ecc_stat_scan`

## Requirements
- R1: While reset is held and in the cycle after it, `done` and `rd_en` are 0 and both totals are 0.
- R2: The status bytes are read at consecutive addresses, starting at offset (META_BYTES + 3) with the two low bits cleared. With the default of 10 metadata bytes this offset is 12. Exactly `chunk_cnt` reads are issued, one per cycle.
- R3: A status byte of 0x00 (clean chunk) changes neither total.
- R4: A status byte of 0xFF (erased chunk) changes neither total.
- R5: A status byte of 0xFE (uncorrectable chunk) adds one to `fail_count` and does not change `corr_total`.
- R6: Every other status byte value (0x01 to 0xFD) is a count of corrected bits and is added to `corr_total`.
- R7: `corr_total` saturates at its all-ones value (65535 by default) and never wraps.
- R8: An accepted start clears both totals at its own clock edge. The totals then hold their values after `done` until the next accepted start.
- R9: `done` is a one-cycle pulse. For N > 0 chunks it is high in the cycle after clock edge N+1, where edge 0 is the edge that samples `start`.
- R10: A chunk count of zero raises `done` in the cycle directly after the start edge, with both totals at 0 and no read issued.
- R11: A `start` that arrives while a scan is under way, including the cycle in which the last status byte returns, is ignored. It has no effect on the reads, the totals or the timing of `done`.
- R12: `rd_data` is taken as the byte addressed one cycle earlier (read latency of one clock).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a scan (ignored while busy) |
| chunk_cnt | input | CNT_W | Number of chunks to scan, sampled with start |
| rd_en | output | 1 | Byte read strobe to the auxiliary buffer |
| rd_addr | output | ADDR_W | Byte address of the status byte being read |
| rd_data | input | 8 | Byte returned one cycle after rd_en |
| corr_total | output | CORR_W | Saturating sum of corrected bits |
| fail_count | output | CNT_W | Number of uncorrectable chunks |
| done | output | 1 | One-cycle pulse when totals are final |

## Verification
The classifier is driven with pages of different makeup:
- All clean or all erased bytes show that the two reserved "nothing to add" codes leave both totals at zero.
- Mixed pages that interleave 0xFE with corrected counts show that failures are counted apart from corrected bits.
- The neighbouring values 0x01 and 0xFD show that the reserved codes are matched exactly and not by range.

Further runs target the boundaries:
- A 300-chunk page of 0xFD separates saturation from wrap-around.
- A zero chunk count checks the immediate `done` with no reads.
- A mid-scan start checks that the running scan is not disturbed.

// File: rtl/esb_pkg.sv
// Shared types and reserved status codes for the ECC status scanner.
package esb_pkg;
    typedef enum logic [1:0] {
        ST_CLEAN  = 2'd0,
        ST_ERASED = 2'd1,
        ST_FAIL   = 2'd2,
        ST_FIXED  = 2'd3
    } stat_kind_e;

    localparam logic [7:0] CODE_CLEAN  = 8'h00;
    localparam logic [7:0] CODE_ERASED = 8'hFF;
    localparam logic [7:0] CODE_FAIL   = 8'hFE;
endpackage

// File: rtl/esb_seq.sv
// Address sequencer: on an accepted start it issues one read per chunk at
// consecutive addresses from BASE_OFF, and tracks which returned beat is
// valid and which is the last. It assumes a read latency of one cycle.
module esb_seq #(
    parameter int CNT_W    = 9,
    parameter int ADDR_W   = 10,
    parameter int BASE_OFF = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  chunk_cnt,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic              accept,
    output logic              zero_done,
    output logic              beat_vld,
    output logic              beat_last
);
    logic [CNT_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q;
    logic             at_last;

    // A start is taken only when no read or returning beat is in flight.
    assign accept    = start && !busy && !beat_vld;
    assign zero_done = accept && (chunk_cnt == '0);
    assign at_last   = busy && (idx_q == cnt_q - CNT_W'(1));
    assign rd_en     = busy;
    assign rd_addr   = ADDR_W'(BASE_OFF) + ADDR_W'(idx_q);

    // Chunk index and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            idx_q <= '0;
            cnt_q <= '0;
        end else if (accept) begin
            busy  <= (chunk_cnt != '0);
            idx_q <= '0;
            cnt_q <= chunk_cnt;
        end else if (busy) begin
            idx_q <= idx_q + CNT_W'(1);
            if (at_last) busy <= 1'b0;
        end
    end

    // Beat qualifiers aligned with the returning read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_vld  <= 1'b0;
            beat_last <= 1'b0;
        end else begin
            beat_vld  <= busy;
            beat_last <= at_last;
        end
    end
endmodule

// File: rtl/esb_classify.sv
// Status byte classifier (combinational): maps a byte onto clean, erased,
// uncorrectable or corrected, and passes on the bit count only for the last.
module esb_classify
    import esb_pkg::*;
(
    input  logic [7:0]  status,
    output stat_kind_e  kind,
    output logic [7:0]  fix_bits
);
    // Reserved codes first, everything else is a corrected-bit count.
    always_comb begin
        fix_bits = 8'h00;
        unique case (status)
            CODE_CLEAN:  kind = ST_CLEAN;
            CODE_ERASED: kind = ST_ERASED;
            CODE_FAIL:   kind = ST_FAIL;
            default: begin
                kind     = ST_FIXED;
                fix_bits = status;
            end
        endcase
    end
endmodule

// File: rtl/esb_accum.sv
// Totals accumulator: clears on an accepted start, adds each classified
// beat (saturating the corrected sum), and pulses done when the totals are
// final. It assumes clear and a valid beat never coincide.
module esb_accum
    import esb_pkg::*;
#(
    parameter int CNT_W  = 9,
    parameter int CORR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              zero_done,
    input  logic              beat_vld,
    input  logic              beat_last,
    input  stat_kind_e        kind,
    input  logic [7:0]        fix_bits,
    output logic [CORR_W-1:0] corr_total,
    output logic [CNT_W-1:0]  fail_count,
    output logic              done
);
    logic [CORR_W:0] sum;

    assign sum = {1'b0, corr_total} + {{(CORR_W-7){1'b0}}, fix_bits};

    // Running totals and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            corr_total <= '0;
            fail_count <= '0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (clear) begin
                corr_total <= '0;
                fail_count <= '0;
                done       <= zero_done;
            end else if (beat_vld) begin
                if (kind == ST_FAIL) fail_count <= fail_count + CNT_W'(1);
                if (kind == ST_FIXED)
                    corr_total <= sum[CORR_W] ? '1 : sum[CORR_W-1:0];
                done <= beat_last;
            end
        end
    end
endmodule

// File: rtl/ecc_stat_scan.sv
// ECC status byte accumulator top: ties the sequencer, classifier and
// accumulator together. It assumes a synchronous buffer with one-cycle
// read latency and a chunk count below 2**CNT_W.
module ecc_stat_scan #(
    parameter int CNT_W      = 9,
    parameter int CORR_W     = 16,
    parameter int META_BYTES = 10,
    localparam int BASE_OFF  = (META_BYTES + 3) & ~3,
    localparam int ADDR_W    = $clog2(BASE_OFF + (1 << CNT_W))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  chunk_cnt,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic [CORR_W-1:0] corr_total,
    output logic [CNT_W-1:0]  fail_count,
    output logic              done
);
    logic                scan_busy;
    logic                accept;
    logic                zero_done;
    logic                beat_vld;
    logic                beat_last;
    esb_pkg::stat_kind_e kind;
    logic [7:0]          fix_bits;

    esb_seq #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .BASE_OFF(BASE_OFF)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .chunk_cnt(chunk_cnt),
        .rd_en(rd_en), .rd_addr(rd_addr), .busy(scan_busy),
        .accept(accept), .zero_done(zero_done),
        .beat_vld(beat_vld), .beat_last(beat_last)
    );

    esb_classify u_cls (
        .status(rd_data), .kind(kind), .fix_bits(fix_bits)
    );

    esb_accum #(.CNT_W(CNT_W), .CORR_W(CORR_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clear(accept), .zero_done(zero_done),
        .beat_vld(beat_vld), .beat_last(beat_last), .kind(kind),
        .fix_bits(fix_bits), .corr_total(corr_total),
        .fail_count(fail_count), .done(done)
    );
endmodule

// File: rtl/esb_checker.sv
// Protocol and invariant checks for ecc_stat_scan, attached by bind.
module esb_checker #(
    parameter int CNT_W    = 9,
    parameter int CORR_W   = 16,
    parameter int ADDR_W   = 10,
    parameter int BASE_OFF = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [CNT_W-1:0]  chunk_cnt,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [CORR_W-1:0] corr_total,
    input logic [CNT_W-1:0]  fail_count,
    input logic              done,
    input logic              scan_busy
);
    // First read of a scan lands on the rounded metadata offset.
    p_first_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en) |-> rd_addr == ADDR_W'(BASE_OFF));

    // Reads inside a scan step by one byte.
    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> rd_addr == $past(rd_addr) + ADDR_W'(1));

    // Without a start the corrected total never falls (no wrap).
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> corr_total >= $past(corr_total));

    // Without a start the failure count never falls.
    p_fail_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> fail_count >= $past(fail_count));

    // Zero chunks: done next cycle with cleared totals.
    p_zero_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !scan_busy && !rd_en && !$past(rd_en) && chunk_cnt == '0)
        |=> (done && corr_total == '0 && fail_count == '0));

    // Done never overlaps an outstanding read.
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_en);
endmodule

bind ecc_stat_scan esb_checker #(
    .CNT_W(CNT_W), .CORR_W(CORR_W), .ADDR_W(ADDR_W), .BASE_OFF(BASE_OFF)
) u_esb_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .chunk_cnt(chunk_cnt),
    .rd_en(rd_en), .rd_addr(rd_addr), .corr_total(corr_total),
    .fail_count(fail_count), .done(done), .scan_busy(scan_busy)
);

// File: tb/ecc_stat_scan_bench.sv
module ecc_stat_scan_bench;
    localparam int CNT_W  = 9;
    localparam int CORR_W = 16;
    localparam int BASE   = 12;
    localparam int AW     = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [CNT_W-1:0]  chunk_cnt = '0;
    logic              rd_en;
    logic [AW-1:0]     rd_addr;
    logic [7:0]        rd_data = 8'h00;
    logic [CORR_W-1:0] corr_total;
    logic [CNT_W-1:0]  fail_count;
    logic              done;

    logic [7:0] mem [0:1023];
    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int t0       = 0;
    int rd_count = 0;
    int addr_err = 0;

    always #5 clk = ~clk;

    ecc_stat_scan u_ecc_stat_scan (
        .clk(clk), .rst_n(rst_n), .start(start), .chunk_cnt(chunk_cnt),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .corr_total(corr_total), .fail_count(fail_count), .done(done)
    );

    // Buffer model with one-cycle read latency (R12).
    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];
    always @(posedge clk) cyc <= cyc + 1;

    // Read monitor: counts reads and checks consecutive addresses from BASE.
    always @(posedge clk) begin
        #2;
        if (rd_en) begin
            if (int'(rd_addr) != BASE + rd_count) addr_err++;
            rd_count++;
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", what, act, exp);
        end
    endtask

    // Reference totals computed from the requirement classes.
    task automatic model(input int n, output int ec, output int ef);
        ec = 0; ef = 0;
        for (int i = 0; i < n; i++) begin
            case (mem[BASE + i])
                8'h00, 8'hFF: ;
                8'hFE: ef++;
                default: begin
                    ec += mem[BASE + i];
                    if (ec > 65535) ec = 65535;
                end
            endcase
        end
    endtask

    task automatic kick(input int n);
        @(negedge clk);
        rd_count = 0; addr_err = 0;
        chunk_cnt = CNT_W'(n);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        t0 = cyc;
    endtask

    task automatic finish_scan(input int n, input string tag);
        int ec, ef, edges;
        while (!done && cyc - t0 < 3000) begin
            @(posedge clk); #1;
        end
        edges = cyc - t0;
        model(n, ec, ef);
        check(done == 1'b1 && edges == (n == 0 ? 0 : n + 1),
              {"R9 done timing ", tag}, edges, n == 0 ? 0 : n + 1);
        check(int'(corr_total) == ec, {"R6 corr_total ", tag}, corr_total, ec);
        check(int'(fail_count) == ef, {"R5 fail_count ", tag}, fail_count, ef);
        check(rd_count == n && addr_err == 0, {"R2 reads ", tag}, rd_count, n);
        @(posedge clk); #1;
        check(done == 1'b0, {"R9 done is one cycle ", tag}, done, 0);
    endtask

    task automatic fill(input int n, input logic [7:0] v);
        for (int i = 0; i < n; i++) mem[BASE + i] = v;
    endtask

    task automatic t_reset();
        check(done == 1'b0 && rd_en == 1'b0, "R1 reset outputs", {done, rd_en}, 0);
        check(corr_total == '0 && fail_count == '0, "R1 reset totals", corr_total, 0);
    endtask

    task automatic t_zero();
        fill(4, 8'h05);
        kick(0);
        check(done == 1'b1, "R10 zero count done", done, 1);
        check(corr_total == '0 && fail_count == '0, "R10 zero totals", corr_total, 0);
        finish_scan(0, "R10");
    endtask

    task automatic t_mixed();
        mem[BASE+0] = 8'h00; mem[BASE+1] = 8'h03; mem[BASE+2] = 8'hFE;
        mem[BASE+3] = 8'hFF; mem[BASE+4] = 8'h11; mem[BASE+5] = 8'hFE;
        mem[BASE+6] = 8'h00; mem[BASE+7] = 8'h02;
        kick(8);
        finish_scan(8, "mixed R3 R4 R5 R6 R12");
    endtask

    task automatic t_clean_erased();
        fill(16, 8'h00);
        kick(16);
        finish_scan(16, "all clean R3");
        fill(16, 8'hFF);
        kick(16);
        finish_scan(16, "all erased R4");
    endtask

    task automatic t_edges();
        mem[BASE+0] = 8'h01; mem[BASE+1] = 8'hFD; mem[BASE+2] = 8'hFE;
        kick(3);
        finish_scan(3, "boundary codes R6");
    endtask

    task automatic t_saturate();
        fill(300, 8'hFD);
        kick(300);
        finish_scan(300, "saturation R7");
        check(corr_total == 16'hFFFF, "R7 saturated", corr_total, 65535);
    endtask

    task automatic t_hold_clear();
        int keep;
        fill(4, 8'h07);
        kick(4);
        finish_scan(4, "hold setup R8");
        keep = corr_total;
        repeat (5) @(posedge clk);
        #1;
        check(int'(corr_total) == keep, "R8 totals hold", corr_total, keep);
        fill(4, 8'h00);
        kick(4);
        check(corr_total == '0, "R8 clear on start", corr_total, 0);
        finish_scan(4, "after clear R8");
    endtask

    task automatic t_ignored_start();
        fill(8, 8'h04);
        mem[BASE+3] = 8'hFE;
        kick(8);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chunk_cnt = CNT_W'(2); start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        finish_scan(8, "restart ignored R11");
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_zero();
        t_mixed();
        t_clean_erased();
        t_edges();
        t_saturate();
        t_hold_clear();
        t_ignored_start();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #1000000;
        n_checks++; n_fail++;
        $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule